// File: doc/BRIEF.md
# Indexed Block Register Target on I2C

This block is an I2C target that owns a small file of eight-bit configuration registers. A host writes a run of registers in one frame. The frame carries the address byte, a starting index and a byte count, and then the data bytes. The block stores each data byte at the current index and steps the index after every byte. The block presents the whole register file on a flat output bus, so the surrounding logic can use the settings directly.

Reads are also frame based. The host writes the address byte and a starting index, issues a repeated start and sends the read address. The block then returns a count byte first. That value comes from a dedicated count register. After the count byte it streams register contents from the starting index until the host declines a byte with a NACK.

A few bit fields are not storage. They show live hardware inputs: a five-bit select field and a one-bit mode pin. Host writes to these bits have no effect. SCL and SDA are synchronised into the system clock, and SDA is driven low only through an output enable. Clock stretching, 10-bit addresses and general call are not supported.

Top module: `i2c_idx_regblk`

## Requirements
- R1: Reset state. Every register reads 0x00, except the count register at index 8, which reads 0x0F. Read-only fields show their hardware inputs. `sda_oe` is 0.
- R2: Address matching.
  - The block acknowledges address byte 0xD2 (write) and 0xD3 (read).
  - Any other address byte is not acknowledged.
  - After an unmatched address, the block acknowledges no byte and changes no register until the next start.
- R3: Write frame. The host sends 0xD2, then index N, then count X, then X data bytes. The block acknowledges every byte and stores the data at indexes N through N+X-1.
- R4: In a write frame, data bytes beyond the count X are not acknowledged and are not stored.
- R5: A counted data byte aimed at an index of 24 or above is acknowledged but stored nowhere. The index does not wrap to low registers.
- R6: Read-only fields ignore host writes:
  - Index 1, bits 4:0, always equal input `hw_sel`.
  - Index 2, bit 7, always equals input `hw_mode`.
- R7: Read frame. The host sends 0xD2, then index N, then a repeated start, then 0xD3.
  - The block first returns the value of the count register.
  - It then returns registers N, N+1, and so on, MSB first.
  - Indexes of 24 or above read as 0x00.
- R8: A host NACK on a read byte ends the transfer. `sda_oe` stays 0 until the next start, so further clocked bytes read as 0xFF.
- R9: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | When 1, pull the data line low |
| hw_sel | input | RBA_W (5) | Live value shown in index 1, bits 4:0 |
| hw_mode | input | 1 | Live value shown in index 2, bit 7 |
| regs_o | output | NREG*8 (192) | Register file; byte i is at bits [8i+7:8i] |

## Verification
The bench uses the default parameters:
- 24 registers.
- The count register at index 8, resetting to 15.
- The read-only fields at indexes 1 and 2.

With 24 registers, a four-byte run starting at index 22 crosses the top of the file. This makes both the ignored high writes and the zero-filled high reads observable within a single frame. Because the count register sits inside the file, an ordinary write frame can reprogram it. The next read frame then shows the new count.

// File: rtl/i2c_idx_regblk.sv
module i2c_idx_regblk #(
  parameter int          NREG     = 24,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int          CNT_IDX  = 8,
  parameter logic [7:0]  CNT_RST  = 8'h0F,
  parameter int          RBA_IDX  = 1,
  parameter int          RBA_W    = 5,
  parameter int          RBB_IDX  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [RBA_W-1:0]  hw_sel,
  input  logic              hw_mode,
  output logic [NREG*8-1:0] regs_o
);
  localparam int         IW    = $clog2(NREG);
  localparam logic [7:0] NREG8 = 8'(NREG);

  function automatic logic [7:0] ro_mask(int i);
    logic [7:0] m;
    m = 8'h00;
    if (i == RBA_IDX) m = m | 8'((1 << RBA_W) - 1);
    if (i == RBB_IDX) m[7] = 1'b1;
    return m;
  endfunction

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_IDX, S_CNT, S_WDAT, S_TX0, S_TX} st_t;

  logic [2:0] scl_r, sda_r;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end

  wire sda_s    = sda_r[1];
  wire start    = scl_r[1] & scl_r[2] & sda_r[2] & ~sda_r[1];
  wire stop     = scl_r[1] & scl_r[2] & ~sda_r[2] & sda_r[1];
  wire scl_rise = scl_r[1] & ~scl_r[2];
  wire scl_fall = ~scl_r[1] & scl_r[2];

  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] sh, idx, left;
  logic       nack;
  logic [7:0] mem  [NREG];
  logic [7:0] view [NREG];
  logic [7:0] rd_byte;

  for (genvar g = 0; g < NREG; g++) begin : g_view
    localparam logic [7:0] M = ro_mask(g);
    wire [7:0] hwb = (g == RBA_IDX ? 8'(hw_sel) : 8'h00) | (g == RBB_IDX ? {hw_mode, 7'h00} : 8'h00);
    assign view[g] = (mem[g] & ~M) | (hwb & M);
    assign regs_o[g*8 +: 8] = view[g];
  end

  assign rd_byte = (idx < NREG8) ? view[idx[IW-1:0]] : 8'h00;

  wire rx = (st == S_ADDR) | (st == S_IDX) | (st == S_CNT) | (st == S_WDAT);
  wire tx = (st == S_TX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= 4'd0;
      sh     <= 8'h00;
      idx    <= 8'h00;
      left   <= 8'h00;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= (i == CNT_IDX) ? CNT_RST : 8'h00;
    end else if (start) begin
      st     <= S_ADDR;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (rx && bitcnt < 4'd8) sh <= {sh[6:0], sda_s};
        if (tx && bitcnt == 4'd8) nack <= sda_s;
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          if (tx) sda_oe <= 1'b0;
          else case (st)
            S_ADDR:
              if (sh == {DEV_ADDR, 1'b0}) begin
                sda_oe <= 1'b1;
                st     <= S_IDX;
              end else if (sh == {DEV_ADDR, 1'b1}) begin
                sda_oe <= 1'b1;
                st     <= S_TX0;
              end else st <= S_IDLE;
            S_IDX: begin
              idx    <= sh;
              sda_oe <= 1'b1;
              st     <= S_CNT;
            end
            S_CNT: begin
              left   <= sh;
              sda_oe <= 1'b1;
              st     <= S_WDAT;
            end
            S_WDAT:
              if (left != 8'h00) begin
                sda_oe <= 1'b1;
                left   <= left - 8'h01;
                idx    <= idx + 8'h01;
                if (idx < NREG8) mem[idx[IW-1:0]] <= sh;
              end
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= 4'd0;
          case (st)
            S_TX0: begin
              st     <= S_TX;
              sh     <= view[CNT_IDX];
              sda_oe <= ~view[CNT_IDX][7];
            end
            S_TX:
              if (nack) begin
                sda_oe <= 1'b0;
                st     <= S_IDLE;
              end else begin
                sh     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                idx    <= idx + 8'h01;
              end
            default: sda_oe <= 1'b0;
          endcase
        end else if (tx && bitcnt != 4'd0) begin
          sh     <= {sh[6:0], 1'b0};
          sda_oe <= ~sh[6];
        end
      end
    end
endmodule

module i2c_idx_regblk_chk #(
  parameter int         NREG    = 24,
  parameter int         CNT_IDX = 8,
  parameter logic [7:0] CNT_RST = 8'h0F,
  parameter int         RBA_IDX = 1,
  parameter int         RBA_W   = 5,
  parameter int         RBB_IDX = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [RBA_W-1:0]  hw_sel,
  input logic              hw_mode,
  input logic [NREG*8-1:0] regs_o
);
  function automatic logic [NREG*8-1:0] wr_mask();
    logic [NREG*8-1:0] m;
    for (int i = 0; i < NREG; i++) begin
      m[i*8 +: 8] = 8'hFF;
      if (i == RBA_IDX) m[i*8 +: 8] = m[i*8 +: 8] & ~8'((1 << RBA_W) - 1);
      if (i == RBB_IDX) m[i*8 + 7] = 1'b0;
    end
    return m;
  endfunction
  localparam logic [NREG*8-1:0] WM = wr_mask();

  always @(negedge clk)
    if (!rst_n) p_reset_cnt_r1: assert (regs_o[CNT_IDX*8 +: 8] == CNT_RST && !sda_oe);

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  p_store_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((regs_o & WM) != $past(regs_o & WM)) |-> !scl_i);

  p_ro_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> regs_o[RBA_IDX*8 +: RBA_W] == hw_sel);

  p_ro_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> regs_o[RBB_IDX*8 + 7] == hw_mode);
endmodule

bind i2c_idx_regblk i2c_idx_regblk_chk #(
  .NREG(NREG), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST),
  .RBA_IDX(RBA_IDX), .RBA_W(RBA_W), .RBB_IDX(RBB_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .hw_sel(hw_sel), .hw_mode(hw_mode), .regs_o(regs_o)
);

// File: tb/tb_i2c_idx_regblk.sv
module tb_i2c_idx_regblk;
  localparam int Q = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic [4:0] hw_sel = 5'h15;
  logic hw_mode = 1'b1;
  logic sda_oe;
  logic [191:0] regs_o;
  wire sda = ~(host_low | sda_oe);
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_idx_regblk dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .hw_sel(hw_sel), .hw_mode(hw_mode), .regs_o(regs_o)
  );

  function automatic logic [7:0] rg(int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_low = 1'b0; w(Q);
    scl = 1'b1; w(Q);
    host_low = 1'b1; w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    host_low = 1'b1; w(Q);
    scl = 1'b1; w(Q);
    host_low = 1'b0; w(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; w(Q);
      scl = 1'b1; w(2*Q);
      scl = 1'b0; w(Q);
    end
    host_low = 1'b0; w(Q);
    scl = 1'b1; w(Q);
    ack = ~sda; w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic rbyte(input logic host_ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      w(Q);
      scl = 1'b1; w(Q);
      b[i] = sda; w(Q);
      scl = 1'b0;
    end
    w(Q);
    host_low = host_ack; w(Q);
    scl = 1'b1; w(2*Q);
    scl = 1'b0; w(Q);
    host_low = 1'b0;
  endtask

  task automatic wr_frame(string req, int n, int x, logic [7:0] d0, logic [7:0] d1,
                          logic [7:0] d2, logic [7:0] d3, int nb, logic [3:0] exp_ack);
    logic a;
    logic [7:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    bus_start();
    wbyte(8'hD2, a); chk("R2", {7'h0, a}, 8'h01);
    wbyte(8'(n), a); chk(req, {7'h0, a}, 8'h01);
    wbyte(8'(x), a); chk(req, {7'h0, a}, 8'h01);
    for (int i = 0; i < nb; i++) begin
      wbyte(d[i], a); chk(req, {7'h0, a}, {7'h0, exp_ack[i]});
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1", rg(8), 8'h0F);
    chk("R1", rg(0), 8'h00);
    chk("R1", rg(23), 8'h00);
    chk("R1", rg(1), 8'h15);
    chk("R1", rg(2), 8'h80);
    chk("R1", {7'h0, sda_oe}, 8'h00);
  endtask

  task automatic t_write();
    wr_frame("R3", 3, 3, 8'hA1, 8'hB2, 8'hC3, 8'h00, 3, 4'b0111);
    chk("R3", rg(3), 8'hA1);
    chk("R3", rg(4), 8'hB2);
    chk("R3", rg(5), 8'hC3);
    chk("R3", rg(6), 8'h00);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    wbyte(8'hA0, a); chk("R2", {7'h0, a}, 8'h00);
    wbyte(8'h05, a); chk("R2", {7'h0, a}, 8'h00);
    wbyte(8'h77, a); chk("R2", {7'h0, a}, 8'h00);
    bus_stop();
    chk("R2", rg(5), 8'hC3);
    bus_start();
    wbyte(8'hD3, a); chk("R2", {7'h0, a}, 8'h01);
    begin
      logic [7:0] b;
      rbyte(1'b0, b); chk("R7", b, 8'h0F);
    end
    bus_stop();
  endtask

  task automatic t_overrun();
    wr_frame("R4", 10, 1, 8'h55, 8'h66, 8'h00, 8'h00, 2, 4'b0001);
    chk("R4", rg(10), 8'h55);
    chk("R4", rg(11), 8'h00);
  endtask

  task automatic t_range();
    wr_frame("R5", 22, 4, 8'h11, 8'h22, 8'h33, 8'h44, 4, 4'b1111);
    chk("R5", rg(22), 8'h11);
    chk("R5", rg(23), 8'h22);
    chk("R5", rg(0), 8'h00);
    chk("R5", rg(1), 8'h15);
  endtask

  task automatic t_ro();
    wr_frame("R6", 1, 2, 8'hFF, 8'h00, 8'h00, 8'h00, 2, 4'b0011);
    chk("R6", rg(1), 8'hF5);
    chk("R6", rg(2), 8'h80);
    hw_sel = 5'h0A; hw_mode = 1'b0; w(2);
    chk("R6", rg(1), 8'hEA);
    chk("R6", rg(2), 8'h00);
  endtask

  task automatic rd_frame(string req, int n, int nb, logic [7:0] e0, logic [7:0] e1,
                          logic [7:0] e2, logic [7:0] e3);
    logic a;
    logic [7:0] b;
    logic [7:0] e [4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    bus_start();
    wbyte(8'hD2, a); chk("R2", {7'h0, a}, 8'h01);
    wbyte(8'(n), a); chk(req, {7'h0, a}, 8'h01);
    bus_start();
    wbyte(8'hD3, a); chk("R2", {7'h0, a}, 8'h01);
    for (int i = 0; i < nb; i++) begin
      rbyte(i != nb - 1, b); chk(req, b, e[i]);
    end
    rbyte(1'b0, b); chk("R8", b, 8'hFF);
    chk("R8", {7'h0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  task automatic t_read();
    wr_frame("R3", 8, 1, 8'h03, 8'h00, 8'h00, 8'h00, 1, 4'b0001);
    chk("R3", rg(8), 8'h03);
    rd_frame("R7", 3, 4, 8'h03, 8'hA1, 8'hB2, 8'hC3);
    rd_frame("R7", 22, 4, 8'h03, 8'h11, 8'h22, 8'h00);
  endtask

  initial begin
    w(5);
    t_reset();
    rst_n = 1'b1;
    w(5);
    t_write();
    t_bad_addr();
    t_overrun();
    t_range();
    t_ro();
    t_read();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule